// File: doc/BRIEF.md
# Masked Event Interrupt Unit

This block passes event flags between a firmware side and a host side and raises one interrupt towards the host. It keeps two 64-bit event sets, each split into a low and a high 32-bit word. The downstream set carries events from the firmware to the host. Firmware raises these bits through a pulse input, and the host clears them by writing ones to an acknowledge register. The upstream set carries events from the host to the firmware. The host raises these bits through register writes, and firmware clears them through a pulse input. Firmware sees the upstream set on a parallel output.

Event bits only accumulate. Setting a bit never clears another bit, and a bit stays set until someone clears it. A host mask enables individual downstream events. A read-only status word shows the downstream events ANDed with the mask. An active-low interrupt output comes from a register and stays low while any enabled downstream event is pending. The host can also poll the event words directly and ignore the interrupt.

The register port has two FSMs. The read FSM has two states, RD_IDLE and RD_RESP. A read request moves it to RD_RESP, or keeps it there for back-to-back reads, and loads the read data. A cycle without a read request returns it to RD_IDLE. The interrupt FSM also has two states, IRQ_QUIET and IRQ_RAISED. It moves from IRQ_QUIET to IRQ_RAISED when any masked downstream bit is set. It moves back to IRQ_QUIET when none is set. irq_n is low exactly in IRQ_RAISED.

Top module: `evt_intr_unit`

## Requirements
- R1: After reset, every event word and mask word reads 0x00000000, and irq_n is high.
- R2: A host write to an upstream event word, or a firmware pulse on fw_set, sets exactly the bits given as 1. All other bits keep their value, so bits accumulate.
- R3: Byte offsets are fixed. The downstream event low and high words are at 0x3C and 0x40. The downstream acknowledge words are at 0x44 and 0x48. The upstream event words are at 0x00 and 0x04. The upstream acknowledge words are at 0x08 and 0x0C. The mask words are at 0x50 and 0x54. The status words are at 0x58 and 0x5C. In each pair the low word holds event bits 31:0.
- R4: A host write of 1 bits to a downstream acknowledge word clears those bits from the next clock. A pulse on fw_up_clr clears upstream bits in the same way. Bits written as 0 are not affected.
- R5: When a bit is set and cleared in the same cycle, it ends up set.
- R6: A status word reads as the downstream event word ANDed with the mask word, where a mask bit of 1 enables that event. Writes to the status words have no effect.
- R7: irq_n goes low one clock after any enabled downstream bit becomes set. It returns high one clock after no enabled bit remains set.
- R8: Upstream events never affect irq_n. fw_up_evt shows the upstream set at all times.
- R9: A read returns reg_rdata with reg_rvalid high in the cycle after the request. Acknowledge words and unmapped offsets read 0. Writes to unmapped offsets have no effect.
- R10: The mask words are read/write and hold the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| reg_rvalid | output | 1 | Read data valid |
| fw_set | input | 64 | Firmware pulse that sets downstream event bits |
| fw_up_clr | input | 64 | Firmware pulse that clears upstream event bits |
| fw_up_evt | output | 64 | Current upstream event bits |
| irq_n | output | 1 | Active-low interrupt to the host |

## Verification
The embedded properties check the following on every cycle:
- a simultaneous set and clear leaves the bit set;
- a cleared bit drops on the next clock;
- no bit is lost unless it was cleared;
- irq_n follows the masked pending condition one clock later;
- read data is valid only the cycle after a read request.

The address map, the status value seen by the host, mask readback, and the absence of effect from writes to status and unmapped offsets can only be shown through the bench's scenarios. The same holds for the independence of irq_n from upstream traffic. The bench shows all of these by comparing against its own reference model on every clock.

// File: rtl/evt_pkg.sv
package evt_pkg;
    localparam int NW = 2;

    localparam int OFS_UP_EVT = 8'h00;
    localparam int OFS_UP_ACK = 8'h08;
    localparam int OFS_DN_EVT = 8'h3C;
    localparam int OFS_DN_ACK = 8'h44;
    localparam int OFS_MASK   = 8'h50;
    localparam int OFS_STAT   = 8'h58;

    typedef enum logic {RD_IDLE, RD_RESP} rd_state_t;
    typedef enum logic {IRQ_QUIET, IRQ_RAISED} irq_state_t;
endpackage

// File: rtl/evt_word_bank.sv
module evt_word_bank #(
    parameter int DW = 32,
    parameter int NW = 2,
    localparam int TW = DW * NW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] set_bits,
    input  logic [TW-1:0] clr_bits,
    output logic [TW-1:0] q
);
    for (genvar w = 0; w < NW; w++) begin : g_word
        logic [DW-1:0] word_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else begin
                word_q <= (word_q & ~clr_bits[w*DW +: DW]) | set_bits[w*DW +: DW];
            end
        end
        assign q[w*DW +: DW] = word_q;
    end

    // R5: a bit set in a cycle is present afterwards even if also cleared
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_bits) |=> ((q & $past(set_bits)) == $past(set_bits)));

    // R4: cleared (and not set) bits are gone on the next clock
    a_r4_clear_next: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_bits) |=> ((q & $past(clr_bits & ~set_bits)) == '0));

    // R2: no bit is lost unless cleared
    a_r2_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((q & $past(q & ~clr_bits)) == $past(q & ~clr_bits)));
endmodule

// File: rtl/evt_regport.sv
module evt_regport
    import evt_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 8,
    localparam int TW = DW * NW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [TW-1:0] up_q,
    input  logic [TW-1:0] dn_q,
    input  logic [TW-1:0] mask_q,
    output logic [TW-1:0] up_set,
    output logic [TW-1:0] dn_clr,
    output logic [NW-1:0] mask_we,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    rd_state_t     rd_state, rd_next;
    logic [DW-1:0] rdata_q;
    logic [DW-1:0] rmux;
    logic          wr_en, rd_en;

    assign wr_en = req && we;
    assign rd_en = req && !we;

    always_comb begin
        up_set  = '0;
        dn_clr  = '0;
        mask_we = '0;
        for (int w = 0; w < NW; w++) begin
            if (wr_en && addr == AW'(OFS_UP_EVT + 4*w)) up_set[w*DW +: DW] = wdata;
            if (wr_en && addr == AW'(OFS_DN_ACK + 4*w)) dn_clr[w*DW +: DW] = wdata;
            if (wr_en && addr == AW'(OFS_MASK + 4*w))   mask_we[w] = 1'b1;
        end
    end

    always_comb begin
        rmux = '0;
        for (int w = 0; w < NW; w++) begin
            if (addr == AW'(OFS_UP_EVT + 4*w)) rmux = up_q[w*DW +: DW];
            if (addr == AW'(OFS_DN_EVT + 4*w)) rmux = dn_q[w*DW +: DW];
            if (addr == AW'(OFS_MASK + 4*w))   rmux = mask_q[w*DW +: DW];
            if (addr == AW'(OFS_STAT + 4*w))   rmux = dn_q[w*DW +: DW] & mask_q[w*DW +: DW];
        end
    end

    always_comb begin
        rd_next = rd_state;
        unique case (rd_state)
            RD_IDLE: if (rd_en) rd_next = RD_RESP;
            RD_RESP: if (!rd_en) rd_next = RD_IDLE;
            default: rd_next = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_state <= RD_IDLE;
        else        rd_state <= rd_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rmux;
    end

    assign rdata  = (rd_state == RD_RESP) ? rdata_q : '0;
    assign rvalid = (rd_state == RD_RESP);

    // R9: valid read data only in the cycle after a read request
    a_r9_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);
    a_r9_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid);
endmodule

// File: rtl/evt_irq_fsm.sv
module evt_irq_fsm
    import evt_pkg::*;
#(
    parameter int DW = 32,
    localparam int TW = DW * NW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] dn_q,
    input  logic [TW-1:0] mask_q,
    output logic          irq_n
);
    irq_state_t st, st_next;
    logic       pending;

    assign pending = |(dn_q & mask_q);

    always_comb begin
        st_next = st;
        unique case (st)
            IRQ_QUIET:  if (pending)  st_next = IRQ_RAISED;
            IRQ_RAISED: if (!pending) st_next = IRQ_QUIET;
            default:    st_next = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= IRQ_QUIET;
        else        st <= st_next;
    end

    always_comb begin
        irq_n = 1'b1;
        unique case (st)
            IRQ_QUIET:  irq_n = 1'b1;
            IRQ_RAISED: irq_n = 1'b0;
            default:    irq_n = 1'b1;
        endcase
    end

    // R7: interrupt follows the enabled pending condition one clock later
    a_r7_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (|(dn_q & mask_q)) |=> !irq_n);
    a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(dn_q & mask_q)) |=> irq_n);
endmodule

// File: rtl/evt_intr_unit.sv
module evt_intr_unit
    import evt_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 8,
    localparam int TW = DW * NW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_req,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          reg_rvalid,
    input  logic [TW-1:0] fw_set,
    input  logic [TW-1:0] fw_up_clr,
    output logic [TW-1:0] fw_up_evt,
    output logic          irq_n
);
    logic [TW-1:0] up_q, dn_q, mask_q;
    logic [TW-1:0] up_set, dn_clr;
    logic [NW-1:0] mask_we;

    evt_regport #(.DW(DW), .AW(AW)) i_port (
        .clk(clk), .rst_n(rst_n),
        .req(reg_req), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .up_q(up_q), .dn_q(dn_q), .mask_q(mask_q),
        .up_set(up_set), .dn_clr(dn_clr), .mask_we(mask_we),
        .rdata(reg_rdata), .rvalid(reg_rvalid)
    );

    evt_word_bank #(.DW(DW), .NW(NW)) i_up_bank (
        .clk(clk), .rst_n(rst_n),
        .set_bits(up_set), .clr_bits(fw_up_clr), .q(up_q)
    );

    evt_word_bank #(.DW(DW), .NW(NW)) i_dn_bank (
        .clk(clk), .rst_n(rst_n),
        .set_bits(fw_set), .clr_bits(dn_clr), .q(dn_q)
    );

    for (genvar w = 0; w < NW; w++) begin : g_mask
        logic [DW-1:0] m_q;
        always_ff @(posedge clk) begin
            if (!rst_n)          m_q <= '0;
            else if (mask_we[w]) m_q <= reg_wdata;
        end
        assign mask_q[w*DW +: DW] = m_q;
    end

    evt_irq_fsm #(.DW(DW)) i_irq (
        .clk(clk), .rst_n(rst_n),
        .dn_q(dn_q), .mask_q(mask_q), .irq_n(irq_n)
    );

    assign fw_up_evt = up_q;

    // R10: a mask word changes only on a write to it
    a_r10_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(|mask_we) |=> $stable(mask_q));
endmodule

// File: tb/test_evt_intr_unit.sv
`timescale 1ns/100ps
module test_evt_intr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 1'b0, reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic [63:0] fw_set = '0, fw_up_clr = '0;
    logic [63:0] fw_up_evt;
    logic        irq_n;

    always #2.5 clk = ~clk;

    evt_intr_unit i_evt_intr_unit (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .fw_set(fw_set), .fw_up_clr(fw_up_clr),
        .fw_up_evt(fw_up_evt), .irq_n(irq_n)
    );

    int vectors = 0;
    int miscompares = 0;
    string phase = "";
    bit done = 0;

    logic [63:0] m_up = '0, m_dn = '0, m_mask = '0;
    logic        exp_irq_n = 1'b1, exp_rvalid = 1'b0;
    logic [31:0] exp_rdata = '0;
    logic [7:0]  last_rd_addr = '0;
    logic [31:0] seed = 32'h1234_5678;

    function automatic logic [31:0] read_model(input logic [7:0] a);
        logic [63:0] st;
        st = m_dn & m_mask;
        case (a)
            8'h00: return m_up[31:0];
            8'h04: return m_up[63:32];
            8'h3C: return m_dn[31:0];
            8'h40: return m_dn[63:32];
            8'h50: return m_mask[31:0];
            8'h54: return m_mask[63:32];
            8'h58: return st[31:0];
            8'h5C: return st[63:32];
            default: return 32'h0;
        endcase
    endfunction

    function automatic string region(input logic [7:0] a);
        case (a)
            8'h00, 8'h04: return "R8";
            8'h3C, 8'h40: return "R2";
            8'h50, 8'h54: return "R10";
            8'h58, 8'h5C: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic model_edge();
        logic [63:0] upset, dnclr;
        logic        wr;
        upset = '0;
        dnclr = '0;
        wr = reg_req && reg_we;
        exp_irq_n  = !(|(m_dn & m_mask));
        exp_rvalid = reg_req && !reg_we;
        if (exp_rvalid) begin
            exp_rdata = read_model(reg_addr);
            last_rd_addr = reg_addr;
        end else begin
            exp_rdata = 32'h0;
        end
        if (wr) begin
            case (reg_addr)
                8'h00: upset[31:0]  = reg_wdata;
                8'h04: upset[63:32] = reg_wdata;
                8'h44: dnclr[31:0]  = reg_wdata;
                8'h48: dnclr[63:32] = reg_wdata;
                8'h50: m_mask[31:0]  = reg_wdata;
                8'h54: m_mask[63:32] = reg_wdata;
                default: ;
            endcase
        end
        m_up = (m_up & ~fw_up_clr) | upset;
        m_dn = (m_dn & ~dnclr) | fw_set;
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    task automatic compare();
        check("R7 irq_n", {63'h0, irq_n}, {63'h0, exp_irq_n});
        check("R8 fw_up_evt", fw_up_evt, m_up);
        check("R9 rvalid", {63'h0, reg_rvalid}, {63'h0, exp_rvalid});
        if (exp_rvalid)
            check((phase != "") ? phase : region(last_rd_addr), {32'h0, reg_rdata}, {32'h0, exp_rdata});
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic idle_in();
        reg_req = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        fw_set = '0; fw_up_clr = '0;
    endtask

    task automatic host_wr(input logic [7:0] a, input logic [31:0] d);
        reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        idle_in();
    endtask

    task automatic host_rd(input logic [7:0] a);
        reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
        step();
        idle_in();
    endtask

    task automatic fw_pulse(input logic [63:0] s, input logic [63:0] c);
        fw_set = s; fw_up_clr = c;
        step();
        idle_in();
    endtask

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R9 watchdog expired: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [7:0] addrs [13];
        addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h3C, 8'h40, 8'h44, 8'h48,
                  8'h50, 8'h54, 8'h58, 8'h5C, 8'h80};
        idle_in();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        phase = "R1";
        compare();
        foreach (addrs[i]) host_rd(addrs[i]);

        // R3: a high-word firmware event appears only at 0x40
        phase = "R3";
        fw_pulse(64'h0000_0100_0000_0000, '0);
        host_rd(8'h40);
        host_rd(8'h3C);
        host_rd(8'h00);

        // R2: accumulation of firmware sets and host upstream writes
        phase = "R2";
        fw_pulse(64'h0000_0000_0000_00F0, '0);
        fw_pulse(64'h0000_0000_0000_0003, '0);
        host_rd(8'h3C);
        host_wr(8'h00, 32'h0000_0011);
        host_wr(8'h00, 32'h0000_0100);
        host_rd(8'h00);

        // R4: acknowledge clears only the 1 bits
        phase = "R4";
        host_wr(8'h44, 32'h0000_0010);
        host_rd(8'h3C);
        host_wr(8'h48, 32'h0000_0100);
        host_rd(8'h40);
        fw_pulse('0, 64'h0000_0000_0000_0001);
        host_rd(8'h00);

        // R5: simultaneous set and clear
        phase = "R5";
        fw_set = 64'h0000_0000_0000_0020;
        host_wr(8'h44, 32'h0000_0020);
        host_rd(8'h3C);
        fw_up_clr = 64'h0000_0000_0000_0200;
        host_wr(8'h00, 32'h0000_0200);
        host_rd(8'h00);

        // R10 and R6: mask readback, status value, status is read-only
        phase = "R10";
        host_wr(8'h50, 32'h0000_0022);
        host_wr(8'h54, 32'hA5A5_0000);
        host_rd(8'h50);
        host_rd(8'h54);
        phase = "R6";
        host_rd(8'h58);
        host_wr(8'h58, 32'hFFFF_FFFF);
        host_rd(8'h58);
        host_rd(8'h5C);

        // R7: interrupt drops after acknowledge, rises on new enabled event
        phase = "R7";
        host_wr(8'h44, 32'hFFFF_FFFF);
        step();
        fw_pulse(64'h0000_0000_0000_0002, '0);
        step();
        host_wr(8'h44, 32'h0000_0002);
        step();

        // R8: upstream events never raise the interrupt
        phase = "R8";
        host_wr(8'h50, 32'hFFFF_FFFF);
        host_wr(8'h54, 32'hFFFF_FFFF);
        host_wr(8'h04, 32'h8000_0001);
        step();
        host_rd(8'h04);

        // R9: ack and unmapped read zero; unmapped write ignored
        phase = "R9";
        host_wr(8'h80, 32'hFFFF_FFFF);
        host_rd(8'h80);
        host_rd(8'h08);
        host_rd(8'h44);
        reg_req = 1'b1; reg_we = 1'b0; reg_addr = 8'h00;
        step();
        reg_addr = 8'h50;
        step();
        idle_in();
        step();

        // mixed traffic
        phase = "";
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = rnd();
            reg_req   = r[0] | r[1];
            reg_we    = r[2];
            reg_addr  = addrs[r[7:4] % 13];
            reg_wdata = rnd() & rnd();
            fw_set    = r[8] ? {rnd() & rnd() & rnd(), rnd() & rnd() & rnd()} : '0;
            fw_up_clr = r[9] ? {rnd(), rnd()} : '0;
            step();
        end
        idle_in();
        step();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule